// File: doc/BRIEF.md
# Real-Time-Clock Alarm Comparator

This block holds a set of alarm bytes and compares them against the running calendar time once per second, at the moment the timekeeping logic signals that its update has finished. When the alarm is armed and every alarm field either equals the matching time field or is marked "don't care", the block raises a match pulse for one clock. Seconds, minutes and hours alarm fields are always present. Day-of-month and month fields are build options. With them the alarm can reach one month or one year ahead, not only one day.

Software reaches the alarm bytes and an arm bit through a small register port: a synchronous write and a combinational read. Writing any alarm field disarms the alarm at once. A match left over from the old setting therefore cannot fire while the fields are being rewritten, and software re-arms once the new time is complete. The compare is a plain byte equality. It works the same whether time and alarm are both kept in BCD or both in binary.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every alarm field that is present reads 0xFF, the control register reads 0x00 (disarmed), and `alarm_hit` is low.
- R2: Register map on `wr_addr`/`rd_addr`: 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 control. Control bit 0 is the arm bit. A written field or arm bit reads back its written value, and unused control bits read zero.
- R3: `alarm_hit` is high for exactly the one clock that follows a clock in which `upd_done` was high, the alarm was armed and every field matched. It is never high at any other time. The compare is raw byte equality, so BCD and binary values are both handled.
- R4: An alarm byte whose bits [7:6] are both 1 (0xFF included) is a wildcard and matches any time value.
- R5: For the day field, only bits [5:0] are compared with `now_day[5:0]`. A day byte whose bits [5:0] are zero is a wildcard.
- R6: When the month field is present, a non-wildcard month byte must equal `now_mon` for a match.
- R7: A write to any alarm field that is present clears the arm bit in the same clock edge.
- R8: While disarmed, no `alarm_hit` is produced even when all fields match.
- R9: When the day or month field is left out by parameter, that field is never compared, reads as 0x00, and writes to its address change nothing, including the arm bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| upd_done | input | 1 | One-clock strobe: time update of this second is complete |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hour | input | 8 | Current hours |
| now_day | input | 8 | Current day of month |
| now_mon | input | 8 | Current month |
| alarm_hit | output | 1 | One-clock alarm match pulse |

## Verification
The compare is driven with time words that match every field, and with words that miss by a single field. A miss in seconds, hours, day or month each shows that the field really takes part in the decision. Each field is also tried with a full 0xFF wildcard, a partial wildcard such as 0xC0 or 0xD5, and a day byte whose low six bits are zero. Together these separate the top-bits rule from the day's own zero rule. A build without the optional fields sees the same stimulus, and its differing results on day and month misses show those fields are left out. Writes around an armed alarm, and a strobe while disarmed, show that rewriting a field suppresses the stale match.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter bit HAS_DAY = 1'b1,
  parameter bit HAS_MON = 1'b1,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          upd_done,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_day,
  input  logic [7:0]    now_mon,
  output logic          alarm_hit
);

  localparam logic [AW-1:0] A_SEC  = AW'(0);
  localparam logic [AW-1:0] A_MIN  = AW'(1);
  localparam logic [AW-1:0] A_HOUR = AW'(2);
  localparam logic [AW-1:0] A_DAY  = AW'(3);
  localparam logic [AW-1:0] A_MON  = AW'(4);
  localparam logic [AW-1:0] A_CTL  = AW'(5);

  logic [7:0] al_sec, al_min, al_hour, al_day, al_mon;
  logic       armed;
  logic       wr_sec, wr_min, wr_hour, wr_day, wr_mon, wr_ctl, fld_wr;
  logic       eq_sec, eq_min, eq_hour, eq_day, eq_mon;

  function automatic logic wild(input logic [7:0] b);
    return &b[7:6];
  endfunction

  assign wr_sec  = wr_en && wr_addr == A_SEC;
  assign wr_min  = wr_en && wr_addr == A_MIN;
  assign wr_hour = wr_en && wr_addr == A_HOUR;
  assign wr_day  = wr_en && wr_addr == A_DAY && HAS_DAY;
  assign wr_mon  = wr_en && wr_addr == A_MON && HAS_MON;
  assign wr_ctl  = wr_en && wr_addr == A_CTL;
  assign fld_wr  = wr_sec | wr_min | wr_hour | wr_day | wr_mon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec  <= 8'hFF;
      al_min  <= 8'hFF;
      al_hour <= 8'hFF;
    end else begin
      if (wr_sec)  al_sec  <= wr_data;
      if (wr_min)  al_min  <= wr_data;
      if (wr_hour) al_hour <= wr_data;
    end
  end

  generate
    if (HAS_DAY) begin : g_day
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      al_day <= 8'hFF;
        else if (wr_day) al_day <= wr_data;
      end
      assign eq_day = wild(al_day) || al_day[5:0] == 6'd0 ||
                      al_day[5:0] == now_day[5:0];
    end else begin : g_no_day
      assign al_day = 8'h00;
      assign eq_day = 1'b1;
    end

    if (HAS_MON) begin : g_mon
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      al_mon <= 8'hFF;
        else if (wr_mon) al_mon <= wr_data;
      end
      assign eq_mon = wild(al_mon) || al_mon == now_mon;
    end else begin : g_no_mon
      assign al_mon = 8'h00;
      assign eq_mon = 1'b1;
    end
  endgenerate

  assign eq_sec  = wild(al_sec)  || al_sec  == now_sec;
  assign eq_min  = wild(al_min)  || al_min  == now_min;
  assign eq_hour = wild(al_hour) || al_hour == now_hour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (fld_wr) armed <= 1'b0;
    else if (wr_ctl) armed <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_hit <= 1'b0;
    else        alarm_hit <= upd_done && armed &&
                             eq_sec && eq_min && eq_hour && eq_day && eq_mon;
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = al_sec;
      A_MIN:   rd_data = al_min;
      A_HOUR:  rd_data = al_hour;
      A_DAY:   rd_data = al_day;
      A_MON:   rd_data = al_mon;
      A_CTL:   rd_data = {7'd0, armed};
      default: rd_data = 8'h00;
    endcase
  end

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data,
  input logic          upd_done,
  input logic          armed,
  input logic          alarm_hit
);

  p_hit_after_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(upd_done));

  p_hit_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(armed));

  p_field_write_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr <= AW'(2)) |=> !armed);

  p_ctl_write_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(5)) |=> armed == $past(wr_data[0]));

  p_sec_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(0)) |=> (rd_addr != AW'(0) || rd_data == $past(wr_data)));

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .upd_done(upd_done), .armed(armed),
  .alarm_hit(alarm_hit)
);

// File: tb/test_rtc_alarm_match.sv
`timescale 1ns/1ps
module test_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_full, rd_mini;
  logic       upd_done = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0, now_mon = '0;
  logic       hit_full, hit_mini;

  int n_chk = 0;
  int n_bad = 0;
  bit q_full[$];
  bit q_mini[$];
  bit seen = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_full), .upd_done(upd_done),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_mon(now_mon), .alarm_hit(hit_full));

  rtc_alarm_match #(.HAS_DAY(1'b0), .HAS_MON(1'b0)) i_rtc_alarm_match_min (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_mini), .upd_done(upd_done),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_mon(now_mon), .alarm_hit(hit_mini));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input int ef, input int em);
    @(negedge clk);
    rd_addr = a;
    #1;
    check({req, " full read"}, rd_full, ef);
    check({req, " reduced read"}, rd_mini, em);
  endtask

  task automatic tick(input logic [7:0] s, m, h, d, mo, input bit ef, input bit em);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_day = d; now_mon = mo;
    upd_done = 1'b1;
    q_full.push_back(ef);
    q_mini.push_back(em);
    @(negedge clk);
    upd_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) seen <= upd_done;

  always @(negedge clk) begin
    if (rst_n) begin
      if (seen) begin
        if (q_full.size() == 0 || q_mini.size() == 0) begin
          check("R3 queue underflow", 1, 0);
        end else begin
          check("R3 full hit", hit_full, q_full.pop_front());
          check("R3 reduced hit", hit_mini, q_mini.pop_front());
        end
      end else begin
        if (hit_full) check("R3 stray full pulse", hit_full, 0);
        if (hit_mini) check("R3 stray reduced pulse", hit_mini, 0);
      end
    end
  end

  initial begin
    #(100000 * 5);
    check("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 hit low in reset", hit_full, 0);
    rst_n = 1'b1;
    rd("R1 sec", 3'd0, 8'hFF, 8'hFF);
    rd("R1 min", 3'd1, 8'hFF, 8'hFF);
    rd("R1 hour", 3'd2, 8'hFF, 8'hFF);
    rd("R1 day (R9 reduced)", 3'd3, 8'hFF, 8'h00);
    rd("R1 mon (R9 reduced)", 3'd4, 8'hFF, 8'h00);
    rd("R1 ctl", 3'd5, 8'h00, 8'h00);
    tick(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 0, 0);            // R8 disarmed

    wr(3'd5, 8'h01);
    rd("R2 ctl armed", 3'd5, 8'h01, 8'h01);
    tick(8'h12, 8'h34, 8'h05, 8'h09, 8'h03, 1, 1);            // R4 all wildcards

    wr(3'd0, 8'h30);
    rd("R2 sec readback", 3'd0, 8'h30, 8'h30);
    rd("R7 sec write disarms", 3'd5, 8'h00, 8'h00);
    tick(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 0, 0);            // R7 stale match suppressed

    wr(3'd5, 8'h01);
    tick(8'h30, 8'h11, 8'h22, 8'h01, 8'h01, 1, 1);            // R3
    tick(8'h31, 8'h11, 8'h22, 8'h01, 8'h01, 0, 0);            // R3 sec miss

    wr(3'd1, 8'h45);
    wr(3'd2, 8'h12);
    rd("R7 hour write disarms", 3'd5, 8'h00, 8'h00);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h01, 8'h01, 1, 1);            // R3
    tick(8'h30, 8'h45, 8'h13, 8'h01, 8'h01, 0, 0);            // R3 hour miss

    wr(3'd3, 8'h15);
    rd("R2 day readback (R9 reduced)", 3'd3, 8'h15, 8'h00);
    rd("R7 day disarms full, R9 reduced kept", 3'd5, 8'h00, 8'h01);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h15, 8'h01, 1, 1);            // R5
    tick(8'h30, 8'h45, 8'h12, 8'h16, 8'h01, 0, 1);            // R5 miss, R9 ignored

    wr(3'd3, 8'hD5);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h16, 8'h01, 1, 1);            // R4 partial wildcard
    wr(3'd3, 8'h40);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h27, 8'h01, 1, 1);            // R5 low bits zero
    wr(3'd3, 8'h55);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h15, 8'h01, 1, 1);            // R5 upper bits ignored
    tick(8'h30, 8'h45, 8'h12, 8'h16, 8'h01, 0, 1);            // R5

    wr(3'd4, 8'h07);
    rd("R2 mon readback (R9 reduced)", 3'd4, 8'h07, 8'h00);
    wr(3'd5, 8'h01);
    tick(8'h30, 8'h45, 8'h12, 8'h15, 8'h07, 1, 1);            // R6
    tick(8'h30, 8'h45, 8'h12, 8'h15, 8'h08, 0, 1);            // R6 miss, R9 ignored

    wr(3'd0, 8'h2D);
    wr(3'd5, 8'h01);
    tick(8'h2D, 8'h45, 8'h12, 8'h15, 8'h07, 1, 1);            // R3 binary value
    tick(8'h45, 8'h45, 8'h12, 8'h15, 8'h07, 0, 0);            // R3 binary miss
    wr(3'd0, 8'hC0);
    wr(3'd5, 8'h01);
    tick(8'h59, 8'h45, 8'h12, 8'h15, 8'h07, 1, 1);            // R4 0xC0 wildcard

    wr(3'd5, 8'h00);
    rd("R2 ctl cleared", 3'd5, 8'h00, 8'h00);
    tick(8'h59, 8'h45, 8'h12, 8'h15, 8'h07, 0, 0);            // R8

    repeat (4) @(negedge clk);
    check("R3 all expected pulses seen", q_full.size() + q_mini.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule